// File: doc/BRIEF.md
# Multi-Cycle Logic Self-Test Sequencer

This block sequences a test-per-scan logic self-test in which every scan load is followed by a burst of functional capture clocks, not just one. A 16-bit pseudo-random generator feeds a set of parallel scan chains through an XOR spreading network, so each chain sees a different bit stream. Once a full load has been shifted in, the sequencer drops scan enable and issues a programmable number of back-to-back capture pulses. Each capture result becomes the stimulus for the next one. During the burst the primary inputs are held frozen, and whatever the circuit drives at intermediate captures is never forwarded.

Only the state left in the chains after the last capture counts as the response. That response is shifted out while the next pattern shifts in. Scan-out bits reach the signature compactor only during passes that unload a real response. After the final pattern, one extra shift pass unloads its response, and then done pulses for one cycle.

Software starts a run with a seed, a pattern count and a capture count. These values are sampled together with the start pulse. The circuit under test and the compactor itself sit outside this block.

Top module: `mcbist_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, scan_en_o, capt_en_o, pi_hold_o, cmp_en_o and done_o are all low.
- R2: A start accepted in idle loads the generator with seed_i, or with 16'h0001 when seed_i is zero. The generator advances once per cycle in which scan_en_o is high and never holds zero. Its update is a left shift that brings in 0, followed by an XOR with 16'hA011 when the old bit 15 was 1. This realises x^16+x^15+x^13+x^4+1.
- R3: In every shift cycle of a load pass, scan_in_o[k] equals s[(3k)%16] ^ s[(3k+5)%16] ^ s[(3k+11)%16], where s is the generator state before that cycle's advance.
- R4: The cycle after an accepted start with a nonzero pattern count begins a shift pass. Every shift pass holds scan_en_o high for exactly CHAIN_LEN consecutive cycles.
- R5: After each load pass, capt_en_o is high and scan_en_o low for exactly C consecutive cycles, followed directly by the next shift pass. C is capt_count_i sampled at start, with 0 replaced by 1 and values above MAX_CAPT replaced by MAX_CAPT.
- R6: pi_hold_o is high in every capture cycle and low in every shift cycle.
- R7: cmp_en_o is high, and cmp_data_o equals scan_out_i, in every shift cycle of every pass except the first. At all other times cmp_en_o is low and cmp_data_o is zero.
- R8: With P patterns (pat_count_i sampled at start), P load passes are followed by one unload-only pass. done_o is then high for one cycle, after which the block is idle. With P = 0, done_o is high in the cycle after start and no shift occurs.
- R9: start_i is ignored while a run is in progress. The timing, scan data and seed of the run are unchanged.
- R10: scan_en_o and capt_en_o are never high in the same cycle, and done_o is never high together with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a run when idle |
| seed_i | input | 16 | Generator seed, sampled with start |
| pat_count_i | input | PAT_W | Number of patterns, sampled with start |
| capt_count_i | input | CAPT_W | Capture cycles per pattern, sampled with start |
| scan_out_i | input | NUM_CHAINS | Chain outputs from the circuit under test |
| scan_en_o | output | 1 | Scan shift enable |
| capt_en_o | output | 1 | Functional capture enable, one pulse per capture cycle |
| pi_hold_o | output | 1 | Freezes primary inputs during the capture burst |
| scan_in_o | output | NUM_CHAINS | Pseudo-random chain inputs |
| cmp_en_o | output | 1 | Compactor accepts cmp_data_o this cycle |
| cmp_data_o | output | NUM_CHAINS | Gated scan-out data for the compactor |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The checker watches every cycle for the properties that need no knowledge of the data. Shift and capture enables never overlap. Each shift run lasts exactly the chain length, and a capture run never exceeds its limit and always hands over to a shift pass. Compactor enable only appears inside shifting. done_o is isolated and lasts a single cycle, and the generator never reaches the all-zero state. The bench has to show the rest: the exact generator sequence and phase-shifter mapping from a given seed, the zero-seed substitution, clamping of the capture count, the number of passes for a pattern count, and that a start arriving mid-run changes nothing.

// File: rtl/mcbist_pkg.sv
// Package: shared state type and generator constants for the multi-cycle
// self-test sequencer. Assumes a fixed 16-bit generator polynomial.
package mcbist_pkg;

    localparam int LFSR_W = 16;
    // Feedback mask for x^16 + x^15 + x^13 + x^4 + 1, left-shifting internal form
    localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hA011;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/mcbist_lfsr.sv
// Module: internal-feedback pseudo-random generator.
// Loads a seed (zero replaced by 1) and advances one step per enabled cycle.
// Assumes load and step are never needed in the same cycle; load wins.
module mcbist_lfsr
    import mcbist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] next_step;

    // Next state: shift left, fold feedback taps when the top bit leaves
    always_comb begin
        next_step = {state[LFSR_W-2:0], 1'b0};
        if (state[LFSR_W-1]) begin
            next_step = next_step ^ LFSR_MASK;
        end
    end

    // State register with seed load and zero-seed guard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LFSR_W'(1);
        end else if (load) begin
            state <= (seed == '0) ? LFSR_W'(1) : seed;
        end else if (step) begin
            state <= next_step;
        end
    end

endmodule

// File: rtl/mcbist_phase.sv
// Module: XOR spreading network between the generator and the chains.
// Chain k takes three generator bits spaced by 0, 5 and 11 from base 3k.
// Purely combinational; assumes NUM_CHAINS >= 1.
module mcbist_phase
    import mcbist_pkg::*;
#(
    parameter int NUM_CHAINS = 4
) (
    input  logic [LFSR_W-1:0]     state,
    output logic [NUM_CHAINS-1:0] chain_bits
);

    // One three-input XOR per chain
    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
        localparam int TAP_A = (3 * k) % LFSR_W;
        localparam int TAP_B = (3 * k + 5) % LFSR_W;
        localparam int TAP_C = (3 * k + 11) % LFSR_W;
        assign chain_bits[k] = state[TAP_A] ^ state[TAP_B] ^ state[TAP_C];
    end

endmodule

// File: rtl/mcbist_fsm.sv
// Module: pass/capture sequencing state machine.
// Runs P load passes each followed by C capture cycles, then one unload pass,
// then a one-cycle done. Counts are sampled on an accepted start; start is
// ignored outside idle. Assumes CHAIN_LEN >= 2 and MAX_CAPT >= 1.
module mcbist_fsm
    import mcbist_pkg::*;
#(
    parameter int CHAIN_LEN = 100,
    parameter int MAX_CAPT  = 50,
    parameter int PAT_W     = 16,
    localparam int CAPT_W   = $clog2(MAX_CAPT + 1),
    localparam int SH_W     = $clog2(CHAIN_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAT_W-1:0]  pat_count,
    input  logic [CAPT_W-1:0] capt_count,
    output logic              load_seed,
    output logic              scan_en,
    output logic              capt_en,
    output logic              pi_hold,
    output logic              unload_en,
    output logic              done
);

    localparam logic [SH_W-1:0]   SH_LAST  = SH_W'(CHAIN_LEN - 1);
    localparam logic [CAPT_W-1:0] CAPT_TOP = CAPT_W'(MAX_CAPT);

    seq_state_e        state_q;
    logic [SH_W-1:0]   sh_q;
    logic [CAPT_W-1:0] cap_q;
    logic [CAPT_W-1:0] cap_lim_q;
    logic [PAT_W-1:0]  pat_q;
    logic [PAT_W-1:0]  pass_q;

    // Limit the requested capture count to the range 1..MAX_CAPT
    function automatic logic [CAPT_W-1:0] clamp_capt(input logic [CAPT_W-1:0] v);
        if (v == '0) begin
            return CAPT_W'(1);
        end else if (v > CAPT_TOP) begin
            return CAPT_TOP;
        end
        return v;
    endfunction

    // Sequencing registers: state, shift/capture counters and pass index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sh_q      <= '0;
            cap_q     <= '0;
            cap_lim_q <= CAPT_W'(1);
            pat_q     <= '0;
            pass_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pat_q     <= pat_count;
                        cap_lim_q <= clamp_capt(capt_count);
                        pass_q    <= '0;
                        sh_q      <= '0;
                        cap_q     <= '0;
                        state_q   <= (pat_count == '0) ? ST_DONE : ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_q == SH_LAST) begin
                        sh_q    <= '0;
                        state_q <= (pass_q == pat_q) ? ST_DONE : ST_CAPT;
                    end else begin
                        sh_q <= sh_q + SH_W'(1);
                    end
                end
                ST_CAPT: begin
                    if (cap_q == cap_lim_q - CAPT_W'(1)) begin
                        cap_q   <= '0;
                        pass_q  <= pass_q + PAT_W'(1);
                        state_q <= ST_SHIFT;
                    end else begin
                        cap_q <= cap_q + CAPT_W'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Output decode from the current state
    always_comb begin
        load_seed = (state_q == ST_IDLE) && start;
        scan_en   = (state_q == ST_SHIFT);
        capt_en   = (state_q == ST_CAPT);
        pi_hold   = (state_q == ST_CAPT);
        unload_en = (state_q == ST_SHIFT) && (pass_q != '0);
        done      = (state_q == ST_DONE);
    end

endmodule

// File: rtl/mcbist_seq.sv
// Module: top of the multi-cycle self-test sequencer.
// Ties the generator, phase shifter and sequencing machine together and
// gates scan-out data toward the compactor. The circuit under test and the
// compactor are external.
module mcbist_seq
    import mcbist_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 100,
    parameter int MAX_CAPT   = 50,
    parameter int PAT_W      = 16,
    localparam int CAPT_W    = $clog2(MAX_CAPT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [LFSR_W-1:0]     seed_i,
    input  logic [PAT_W-1:0]      pat_count_i,
    input  logic [CAPT_W-1:0]     capt_count_i,
    input  logic [NUM_CHAINS-1:0] scan_out_i,
    output logic                  scan_en_o,
    output logic                  capt_en_o,
    output logic                  pi_hold_o,
    output logic [NUM_CHAINS-1:0] scan_in_o,
    output logic                  cmp_en_o,
    output logic [NUM_CHAINS-1:0] cmp_data_o,
    output logic                  done_o
);

    logic              load_seed;
    logic              unload_en;
    logic [LFSR_W-1:0] lfsr_q;

    mcbist_fsm #(
        .CHAIN_LEN (CHAIN_LEN),
        .MAX_CAPT  (MAX_CAPT),
        .PAT_W     (PAT_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .pat_count  (pat_count_i),
        .capt_count (capt_count_i),
        .load_seed  (load_seed),
        .scan_en    (scan_en_o),
        .capt_en    (capt_en_o),
        .pi_hold    (pi_hold_o),
        .unload_en  (unload_en),
        .done       (done_o)
    );

    mcbist_lfsr lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_seed),
        .seed  (seed_i),
        .step  (scan_en_o),
        .state (lfsr_q)
    );

    mcbist_phase #(
        .NUM_CHAINS (NUM_CHAINS)
    ) phase_i (
        .state      (lfsr_q),
        .chain_bits (scan_in_o)
    );

    // Forward scan-out only while a real response is being unloaded
    always_comb begin
        cmp_en_o   = unload_en;
        cmp_data_o = unload_en ? scan_out_i : '0;
    end

endmodule

// File: rtl/mcbist_seq_chk.sv
// Module: protocol checker for the sequencer, bound to the top module.
// Uses run-length counters so long windows need no deep $past.
module mcbist_seq_chk #(
    parameter int CHAIN_LEN = 100,
    parameter int MAX_CAPT  = 50
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scan_en,
    input logic        capt_en,
    input logic        pi_hold,
    input logic        cmp_en,
    input logic        done,
    input logic [15:0] lfsr_state
);

    int unsigned run_sh;
    int unsigned run_cp;

    // Consecutive-cycle counters for shift and capture runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_sh <= 0;
            run_cp <= 0;
        end else begin
            run_sh <= scan_en ? run_sh + 1 : 0;
            run_cp <= capt_en ? run_cp + 1 : 0;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && capt_en));
    a_r10_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !capt_en));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_shift_bound: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (run_sh < CHAIN_LEN));
    a_r4_shift_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (run_sh == CHAIN_LEN));
    a_r5_capt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        capt_en |-> (run_cp < MAX_CAPT));
    a_r5_capt_to_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(capt_en) |-> scan_en);
    a_r6_hold_in_capt: assert property (@(posedge clk) disable iff (!rst_n)
        capt_en |-> pi_hold);
    a_r7_cmp_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> scan_en);
    a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != 16'h0000);

endmodule

bind mcbist_seq mcbist_seq_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .MAX_CAPT  (MAX_CAPT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en_o),
    .capt_en    (capt_en_o),
    .pi_hold    (pi_hold_o),
    .cmp_en     (cmp_en_o),
    .done       (done_o),
    .lfsr_state (lfsr_q)
);

// File: tb/mcbist_seq_tb_top.sv
`timescale 1ns/1ps
module mcbist_seq_tb_top;

    localparam int NC    = 4;
    localparam int L     = 12;
    localparam int MAXC  = 50;
    localparam int PW    = 16;
    localparam int CW    = $clog2(MAXC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [15:0]   seed_i = '0;
    logic [PW-1:0] pat_count_i = '0;
    logic [CW-1:0] capt_count_i = '0;
    logic [NC-1:0] scan_out_i = '0;
    logic          scan_en_o, capt_en_o, pi_hold_o, cmp_en_o, done_o;
    logic [NC-1:0] scan_in_o, cmp_data_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mcbist_seq #(
        .NUM_CHAINS (NC),
        .CHAIN_LEN  (L),
        .MAX_CAPT   (MAXC),
        .PAT_W      (PW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .seed_i       (seed_i),
        .pat_count_i  (pat_count_i),
        .capt_count_i (capt_count_i),
        .scan_out_i   (scan_out_i),
        .scan_en_o    (scan_en_o),
        .capt_en_o    (capt_en_o),
        .pi_hold_o    (pi_hold_o),
        .scan_in_o    (scan_in_o),
        .cmp_en_o     (cmp_en_o),
        .cmp_data_o   (cmp_data_o),
        .done_o       (done_o)
    );

    function automatic logic [15:0] gen_next(input logic [15:0] s);
        logic [15:0] n;
        n = {s[14:0], 1'b0};
        if (s[15]) n = n ^ 16'hA011;
        return n;
    endfunction

    function automatic logic [NC-1:0] spread(input logic [15:0] s);
        logic [NC-1:0] r;
        for (int k = 0; k < NC; k++) begin
            r[k] = s[(3*k) % 16] ^ s[(3*k+5) % 16] ^ s[(3*k+11) % 16];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One run: start, then step through every expected cycle
    task automatic run(input logic [15:0] seed, input int p_n, input int c_n, input bit inject);
        logic [15:0] m;
        int          c_eff;
        m     = (seed == 16'h0) ? 16'h0001 : seed;
        c_eff = (c_n == 0) ? 1 : ((c_n > MAXC) ? MAXC : c_n);
        seed_i       = seed;
        pat_count_i  = PW'(p_n);
        capt_count_i = CW'(c_n);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (p_n == 0) begin
            #1;
            chk("R8 zero patterns done", 32'(done_o), 32'd1);
            chk("R8 zero patterns no shift", 32'(scan_en_o), 32'd0);
        end else begin
            for (int p = 0; p <= p_n; p++) begin
                for (int i = 0; i < L; i++) begin
                    scan_out_i = NC'($urandom);
                    #1;
                    chk("R4 scan_en in shift", 32'(scan_en_o), 32'd1);
                    chk("R10 no capture in shift", 32'(capt_en_o), 32'd0);
                    chk("R6 hold low in shift", 32'(pi_hold_o), 32'd0);
                    chk("R7 cmp_en", 32'(cmp_en_o), 32'((p > 0) ? 1 : 0));
                    chk("R7 cmp_data", 32'(cmp_data_o), (p > 0) ? 32'(scan_out_i) : 32'd0);
                    if (p < p_n) begin
                        chk("R2 R3 scan_in", 32'(scan_in_o), 32'(spread(m)));
                    end
                    m = gen_next(m);
                    if (inject && p == 0 && i == 2) begin
                        start_i = 1'b1;
                        seed_i  = 16'h1234;
                        pat_count_i  = PW'(7);
                        capt_count_i = CW'(9);
                    end else begin
                        start_i = 1'b0;
                    end
                    @(negedge clk);
                end
                if (p < p_n) begin
                    for (int j = 0; j < c_eff; j++) begin
                        #1;
                        chk("R5 capture pulse", 32'(capt_en_o), 32'd1);
                        chk("R5 no shift in capture", 32'(scan_en_o), 32'd0);
                        chk("R6 hold in capture", 32'(pi_hold_o), 32'd1);
                        chk("R7 cmp_en off in capture", 32'(cmp_en_o), 32'd0);
                        chk("R8 done low mid-run", 32'(done_o), 32'd0);
                        @(negedge clk);
                    end
                end
            end
            #1;
            chk("R8 done after unload", 32'(done_o), 32'd1);
            chk("R10 done alone", 32'(scan_en_o | capt_en_o), 32'd0);
        end
        @(negedge clk);
        #1;
        chk("R8 single-cycle done", 32'(done_o), 32'd0);
        chk("R8 idle after done", 32'(scan_en_o | capt_en_o), 32'd0);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset scan_en", 32'(scan_en_o), 32'd0);
        chk("R1 reset capt_en", 32'(capt_en_o), 32'd0);
        chk("R1 reset done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after reset outputs", 32'({scan_en_o, capt_en_o, pi_hold_o, cmp_en_o, done_o}), 32'd0);
        @(negedge clk);

        run(16'hA5C3, 2, 3, 1'b0);
        run(16'h0000, 1, 1, 1'b0);   // R2 zero seed
        run(16'h8001, 1, 0, 1'b0);   // R5 clamp low
        run(16'h4F1E, 1, 60, 1'b0);  // R5 clamp high
        run(16'h3333, 0, 4, 1'b0);   // R8 zero patterns
        run(16'hBEEF, 2, 2, 1'b1);   // R9 start ignored mid-run
        run(16'hFFFF, 1, MAXC, 1'b0);
        for (int r = 0; r < 6; r++) begin
            run(16'($urandom), 1 + int'($urandom % 3), int'($urandom % 8), 1'b0);
        end

        summary();
        $finish;
    end

endmodule